// File: doc/BRIEF.md
# Branch Decision and Flag-Op Unit

This unit sits in the decode stage of a 16-bit processor. For each fetched instruction word offered with a strobe, it classifies the word as a conditional branch, a condition-code set/clear operation, or something else. For a branch, it evaluates the branch condition against the current N, Z, V and C flags. It also forms the branch target from the already-incremented program counter and a signed word offset held in the low byte. For a set/clear operation, it produces the new four-flag value from a sense bit and a four-bit mask. With one instruction, any combination of flags can be forced to one or to zero.

The decision is combinational. Its result is captured one clock after the strobe by a small state machine. The state register holds the class of the last strobed word. The states are:
- ST_IDLE: no result.
- ST_BRANCH: branch result.
- ST_FLAGOP: flag-op result.
- ST_OTHER: strobed but not recognised.

Every state moves to the class state of the word on the next strobe, or to ST_IDLE when there is no strobe. The outputs are decoded from the state and the registered results.

Top module: `bu_unit`

## Requirements
- R1: After reset, and before the first strobe, res_valid, recognised, br_taken, flag_we, br_target and flag_new are all zero.
- R2: res_valid is high in exactly the cycle after each instr_valid cycle. Without a strobe, it is low and every other output is zero.
- R3: For a branch, br_target equals pc_next plus twice the sign-extended offset instr[7:0], taken modulo 2^16. This holds whether or not the branch is taken.
- R4: A word with instr[15]=0 and instr[14:11]=0 is a branch when its code instr[10:8] is nonzero. The code decides the condition: 001 always taken, 010 Z=0, 011 Z=1, 100 N^V=0, 101 N^V=1, 110 (Z|(N^V))=0, 111 (Z|(N^V))=1.
- R5: A word with instr[15]=1 and instr[14:11]=0 is always a branch, on instr[10:8]. The code decides the condition: 000 N=0, 001 N=1, 010 C=0 and Z=0, 011 C|Z=1, 100 V=0, 101 V=1, 110 C=0, 111 C=1.
- R6: A word with instr[15:8]=8'h00 is never a branch. The byte-swap word lives in this range. br_taken stays 0, and recognised is 1 only for the flag-op words of R7.
- R7: A word with instr[15:5]=11'b00000000101 (octal 000240 to 000277) is a flag-op. It gives recognised=1, flag_we=1 and br_taken=0.
- R8: flags_in and flag_new use the bit order {N,Z,V,C}, from bit 3 down to bit 0. For a flag-op, flag_new is flags_in|instr[3:0] when the sense bit instr[4] is 1, and flags_in&~instr[3:0] when instr[4] is 0.
- R9: Octal words 000240 and 000260 give flag_new equal to the flags_in sampled with the strobe.
- R10: A strobed word that is neither a branch nor a flag-op gives res_valid=1 with recognised, br_taken and flag_we all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Strobe: instr, pc_next and flags_in are valid |
| instr | input | 16 | Fetched instruction word |
| pc_next | input | 16 | Address of the word after the instruction |
| flags_in | input | 4 | Current flags {N,Z,V,C} |
| res_valid | output | 1 | Result of the previous strobe is present |
| recognised | output | 1 | Word was a branch or a flag-op |
| br_taken | output | 1 | Branch condition held |
| br_target | output | 16 | Branch target address (zero unless a branch) |
| flag_we | output | 1 | Flag-op result present |
| flag_new | output | 4 | New flags {N,Z,V,C} for a flag-op |

## Verification
Random branch words are combined with all sixteen flag patterns. This separates each of the fifteen branch conditions from its complement, and the N^V forms from the plain N or V forms. Random offsets with random pc_next values, including values near 0 and 16'hFFFF, show sign extension, word scaling and wrap in the target. Random flag-op words with random flags separate the set sense from the clear sense and reveal any mask bit that is mapped to the wrong flag. Fully random words, plus directed byte-swap, 000240 and 000260 words, show that the class boundaries are decoded exactly.

// File: rtl/bu_pkg.sv
package bu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BRANCH = 2'd1,
        ST_FLAGOP = 2'd2,
        ST_OTHER  = 2'd3
    } bu_state_e;

    localparam int FLG_N = 3;
    localparam int FLG_Z = 2;
    localparam int FLG_V = 1;
    localparam int FLG_C = 0;
endpackage

// File: rtl/bu_decode.sv
module bu_decode
    import bu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int FLAG_W = 4
) (
    input  logic [DATA_W-1:0] instr,
    input  logic [FLAG_W-1:0] flags,
    output bu_state_e         cls,
    output logic              cond_ok
);
    localparam int TOP = DATA_W - 1;

    logic       n, z, v, c, nxv;
    logic [3:0] sel;
    logic       is_br, is_fop;

    assign n   = flags[FLG_N];
    assign z   = flags[FLG_Z];
    assign v   = flags[FLG_V];
    assign c   = flags[FLG_C];
    assign nxv = n ^ v;
    assign sel = {instr[TOP], instr[10:8]};

    // branch space: bits 14:11 clear, excluding sign-0/code-0 slot
    assign is_br  = (instr[TOP-1:11] == '0) && (sel != 4'b0000);
    // condition-code family: octal 00024x .. 00027x
    assign is_fop = (instr[TOP:5] == 11'b00000000101);

    always_comb begin
        unique case (sel)
            4'b0000: cond_ok = 1'b0;
            4'b0001: cond_ok = 1'b1;
            4'b0010: cond_ok = ~z;
            4'b0011: cond_ok = z;
            4'b0100: cond_ok = ~nxv;
            4'b0101: cond_ok = nxv;
            4'b0110: cond_ok = ~(z | nxv);
            4'b0111: cond_ok = z | nxv;
            4'b1000: cond_ok = ~n;
            4'b1001: cond_ok = n;
            4'b1010: cond_ok = ~(c | z);
            4'b1011: cond_ok = c | z;
            4'b1100: cond_ok = ~v;
            4'b1101: cond_ok = v;
            4'b1110: cond_ok = ~c;
            4'b1111: cond_ok = c;
            default: cond_ok = 1'b0;
        endcase
    end

    always_comb begin
        if (is_br)       cls = ST_BRANCH;
        else if (is_fop) cls = ST_FLAGOP;
        else             cls = ST_OTHER;
    end
endmodule

// File: rtl/bu_target.sv
module bu_target #(
    parameter int DATA_W = 16,
    parameter int OFF_W  = 8
) (
    input  logic [DATA_W-1:0] pc_next,
    input  logic [OFF_W-1:0]  offset,
    output logic [DATA_W-1:0] target
);
    localparam int EXT_W = DATA_W - OFF_W - 1;

    logic [DATA_W-1:0] byte_disp;

    assign byte_disp = {{EXT_W{offset[OFF_W-1]}}, offset, 1'b0};
    assign target    = pc_next + byte_disp;
endmodule

// File: rtl/bu_flagop.sv
module bu_flagop #(
    parameter int FLAG_W = 4
) (
    input  logic [FLAG_W-1:0] flags,
    input  logic              sense,
    input  logic [FLAG_W-1:0] mask,
    output logic [FLAG_W-1:0] result
);
    always_comb begin
        if (sense) result = flags | mask;
        else       result = flags & ~mask;
    end
endmodule

// File: rtl/bu_unit.sv
module bu_unit
    import bu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int OFF_W  = 8,
    parameter int FLAG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [DATA_W-1:0] instr,
    input  logic [DATA_W-1:0] pc_next,
    input  logic [FLAG_W-1:0] flags_in,
    output logic              res_valid,
    output logic              recognised,
    output logic              br_taken,
    output logic [DATA_W-1:0] br_target,
    output logic              flag_we,
    output logic [FLAG_W-1:0] flag_new
);
    localparam int SENSE_BIT = FLAG_W;

    bu_state_e         state_q, state_d, cls;
    logic              cond_ok;
    logic [DATA_W-1:0] tgt_d;
    logic [FLAG_W-1:0] fop_d;

    logic              taken_q;
    logic [DATA_W-1:0] tgt_q;
    logic [FLAG_W-1:0] fop_q;

    bu_decode #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_dec (
        .instr   (instr),
        .flags   (flags_in),
        .cls     (cls),
        .cond_ok (cond_ok)
    );

    bu_target #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_tgt (
        .pc_next (pc_next),
        .offset  (instr[OFF_W-1:0]),
        .target  (tgt_d)
    );

    bu_flagop #(.FLAG_W(FLAG_W)) u_fop (
        .flags  (flags_in),
        .sense  (instr[SENSE_BIT]),
        .mask   (instr[FLAG_W-1:0]),
        .result (fop_d)
    );

    // next-state: each state moves to the class of a strobed word, else idle
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_BRANCH, ST_FLAGOP, ST_OTHER: begin
                if (instr_valid) state_d = cls;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            taken_q <= 1'b0;
            tgt_q   <= '0;
            fop_q   <= '0;
        end else begin
            state_q <= state_d;
            if (instr_valid) begin
                taken_q <= cond_ok;
                tgt_q   <= tgt_d;
                fop_q   <= fop_d;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        res_valid  = 1'b0;
        recognised = 1'b0;
        br_taken   = 1'b0;
        br_target  = '0;
        flag_we    = 1'b0;
        flag_new   = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_BRANCH: begin
                res_valid  = 1'b1;
                recognised = 1'b1;
                br_taken   = taken_q;
                br_target  = tgt_q;
            end
            ST_FLAGOP: begin
                res_valid  = 1'b1;
                recognised = 1'b1;
                flag_we    = 1'b1;
                flag_new   = fop_q;
            end
            ST_OTHER: res_valid = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/bu_unit_chk.sv
module bu_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        instr_valid,
    input logic [15:0] instr,
    input logic [15:0] pc_next,
    input logic [3:0]  flags_in,
    input logic        res_valid,
    input logic        recognised,
    input logic        br_taken,
    input logic [15:0] br_target,
    input logic        flag_we,
    input logic [3:0]  flag_new
);
    logic started;
    always_ff @(posedge clk) begin
        if (!rst_n) started <= 1'b0;
        else        started <= 1'b1;
    end

    AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |=> res_valid); // R2

    AST_QUIET_WITHOUT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!recognised && !br_taken && !flag_we)); // R2

    AST_ALWAYS_BRANCH_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr[15:8] == 8'h01) |=> br_taken); // R4

    AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr[15:11] == 5'b10000) |=>
        br_target == 16'($past(pc_next) + {{7{$past(instr[7])}}, $past(instr[7:0]), 1'b0})); // R3

    AST_SWAP_RANGE_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr[15:8] == 8'h00) |=> !br_taken); // R6

    AST_FLAG_NOP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && (instr == 16'h00A0 || instr == 16'h00B0)) |=>
        (flag_we && flag_new == $past(flags_in))); // R9

    AST_FLAGOP_NOT_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |-> (!br_taken && recognised)); // R7

    always_comb begin
        if (rst_n && started)
            AST_TAKEN_NEEDS_VALID: assert (!br_taken || res_valid); // R2
    end
endmodule

bind bu_unit bu_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr       (instr),
    .pc_next     (pc_next),
    .flags_in    (flags_in),
    .res_valid   (res_valid),
    .recognised  (recognised),
    .br_taken    (br_taken),
    .br_target   (br_target),
    .flag_we     (flag_we),
    .flag_new    (flag_new)
);

// File: tb/bu_unit_tb.sv
module bu_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        instr_valid;
    logic [15:0] instr;
    logic [15:0] pc_next;
    logic [3:0]  flags_in;
    logic        res_valid, recognised, br_taken, flag_we;
    logic [15:0] br_target;
    logic [3:0]  flag_new;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    bu_unit u_dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .pc_next(pc_next), .flags_in(flags_in), .res_valid(res_valid),
        .recognised(recognised), .br_taken(br_taken), .br_target(br_target),
        .flag_we(flag_we), .flag_new(flag_new)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h (instr=%o)", req, act, exp, instr);
        end
    endtask

    function automatic bit cond_of(input logic [15:0] w, input logic [3:0] f);
        logic n, z, v, c;
        {n, z, v, c} = f;
        if (!w[15]) begin
            case (w[10:8])
                3'd1: return 1'b1;
                3'd2: return !z;
                3'd3: return z;
                3'd4: return (n ^ v) == 1'b0;
                3'd5: return (n ^ v) == 1'b1;
                3'd6: return (z | (n ^ v)) == 1'b0;
                3'd7: return (z | (n ^ v)) == 1'b1;
                default: return 1'b0;
            endcase
        end else begin
            case (w[10:8])
                3'd0: return !n;
                3'd1: return n;
                3'd2: return !c && !z;
                3'd3: return c || z;
                3'd4: return !v;
                3'd5: return v;
                3'd6: return !c;
                default: return c;
            endcase
        end
    endfunction

    // drive one word at negedge, check at the following negedge
    task automatic run_one(input logic [15:0] w, input logic [15:0] pc, input logic [3:0] f);
        bit is_br, is_fop, e_tk;
        logic [15:0] e_tgt;
        logic [3:0]  e_fl;
        instr = w; pc_next = pc; flags_in = f; instr_valid = 1'b1;
        is_br  = (w[14:11] == 4'd0) && !(w[15] == 1'b0 && w[10:8] == 3'd0);
        is_fop = (w[15:5] == 11'b00000000101);
        e_tk   = is_br && cond_of(w, f);
        e_tgt  = pc + {{7{w[7]}}, w[7:0], 1'b0};
        e_fl   = w[4] ? (f | w[3:0]) : (f & ~w[3:0]);
        @(negedge clk);
        instr_valid = 1'b0;
        chk(res_valid == 1'b1, "R2 valid after strobe", 32'(res_valid), 1);
        if (is_br) begin
            chk(recognised == 1'b1, "R4/R5 branch recognised", 32'(recognised), 1);
            if (w[15]) chk(br_taken == e_tk, "R5 sign-1 condition", 32'(br_taken), 32'(e_tk));
            else       chk(br_taken == e_tk, "R4 sign-0 condition", 32'(br_taken), 32'(e_tk));
            chk(br_target == e_tgt, "R3 target", 32'(br_target), 32'(e_tgt));
            chk(flag_we == 1'b0, "R7 no flag write on branch", 32'(flag_we), 0);
        end else if (is_fop) begin
            chk(recognised && flag_we && !br_taken, "R7 flag-op class",
                {29'd0, recognised, flag_we, br_taken}, 32'b110);
            chk(flag_new == e_fl, "R8 flag result", 32'(flag_new), 32'(e_fl));
        end else begin
            chk(!recognised && !br_taken && !flag_we, "R10 unrecognised word",
                {29'd0, recognised, br_taken, flag_we}, 0);
        end
        if (w[15:8] == 8'h00)
            chk(br_taken == 1'b0, "R6 swap range never taken", 32'(br_taken), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        void'($urandom(32'd1234));
        rst_n = 1'b0; instr_valid = 1'b0; instr = '0; pc_next = '0; flags_in = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!res_valid && !recognised && !br_taken && !flag_we && br_target == 0 && flag_new == 0,
            "R1 reset outputs", {res_valid, recognised, br_taken, flag_we, br_target, 8'(flag_new)}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(res_valid == 1'b0, "R1 idle after reset", 32'(res_valid), 0);

        // directed corners
        run_one(16'o000400, 16'h1000, 4'h0);            // always, offset 0
        run_one(16'o000777, 16'h0000, 4'h0);            // R3 wrap below zero
        run_one(16'o000577, 16'hFFFE, 4'hF);            // R3 wrap above top
        run_one(16'o100000, 16'h0200, 4'b0111);         // R5 N=0 taken
        run_one(16'o000300, 16'h0200, 4'h0);            // R6 byte-swap word
        run_one(16'o000240, 16'h0, 4'b1010);            // R9
        chk(flag_new == 4'b1010, "R9 000240 keeps flags", 32'(flag_new), 32'hA);
        run_one(16'o000260, 16'h0, 4'b0101);            // R9
        chk(flag_new == 4'b0101, "R9 000260 keeps flags", 32'(flag_new), 32'h5);
        run_one(16'o000277, 16'h0, 4'b0000);            // R8 set all
        run_one(16'o000257, 16'h0, 4'b1111);            // R8 clear all
        run_one(16'o000241, 16'h0, 4'b1111);            // R8 clear C only
        run_one(16'o000200, 16'h0, 4'b1111);            // R10 just below family
        run_one(16'o000300 - 16'd1 + 16'd1, 16'h0, 4'h0);
        // R2: gap with no strobe
        @(negedge clk);
        chk(!res_valid && !flag_we && !br_taken, "R2 low without strobe",
            {29'd0, res_valid, flag_we, br_taken}, 0);

        for (int i = 0; i < 3000; i++) begin
            case ($urandom_range(0, 2))
                0: w = {1'($urandom), 4'b0000, 3'($urandom), 8'($urandom)};
                1: w = {11'b00000000101, 5'($urandom)};
                default: w = 16'($urandom);
            endcase
            run_one(w, 16'($urandom), 4'($urandom));
            if ($urandom_range(0, 7) == 0) begin
                @(negedge clk);
                chk(res_valid == 1'b0, "R2 idle gap", 32'(res_valid), 0);
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule